// File: doc/BRIEF.md
# DMA Master Transfer Sizing Unit

This block sits between a DMA engine and a bus master. It turns one transfer request into the exact list of bus accesses that carry it. A request holds a start address, a byte count, an end-of-message flag and a kind. The four kinds are outgoing data, incoming data, a descriptor status write and a full descriptor write. For each access the block gives an aligned address, the access width (32 or 64 bits) and active-low byte enables, and it marks the final access of the request.

Quasi-static configuration inputs shape the access list. They select the bus width, whether the target is known to accept 64-bit accesses, an ECC-memory mode and the storage byte order. In ECC mode the memory is only written in whole 64-bit words where the rules require it. Data pointers are treated as 64-bit aligned, descriptor status updates widen to the whole descriptor, and incoming data without end of message is padded to a 64-bit boundary. The block accepts one request at a time and presents its accesses one after another under a valid/ready handshake.

Top module: `dma_sizer`

## Requirements
- R1: After reset, req_ready is 1 and acc_valid is 0.
- R2: A request is taken on a cycle with req_valid and req_ready both high. acc_valid rises in the following cycle. req_ready stays 0 until the cycle after the access with acc_last=1 is taken with acc_ready=1. While acc_valid is high and acc_ready is low, acc_addr, acc_wide and acc_be_n hold their values.
- R3: When cfg_bus64=0, every access is 32-bit (acc_wide=0). Accesses cover, in ascending address order, each aligned dword that holds at least one byte of the transfer. The low dword of any 64-bit word comes before its high dword.
- R4: When cfg_bus64=1, cfg_target64=0 and all transfer bytes lie in a single aligned 64-bit word, the transfer is issued as 32-bit accesses, one for each dword holding transfer bytes. A full 8-byte word therefore becomes two accesses.
- R5: When cfg_bus64=1 and either cfg_target64=1 or the transfer spans more than one aligned 64-bit word, every access is 64-bit (acc_wide=1) at an 8-byte aligned address, in ascending order.
- R6: acc_be_n bit i is 0 only for a lane carrying a transfer byte. With little-endian order (cfg_big_endian=0), lane i carries address acc_addr+i. A 32-bit access uses lanes 0 to 3 and holds acc_be_n[7:4] at 1. Every access enables at least one byte.
- R7: With cfg_big_endian=1, the byte at offset k of an access that is W bytes wide (W=4 or 8) travels on lane W-1-k.
- R8: Descriptor kinds ignore req_len and req_eom, and req_addr is the descriptor base with its low three bits at 0. Kind 3 (full write) covers 8 bytes from the base. Kind 2 (status write) with cfg_ecc=0 covers the 4 bytes at base+4.
- R9: With cfg_ecc=1, kind 2 covers the full 8 bytes from the base, the same as kind 3.
- R10: With cfg_ecc=1, data kinds (0 outgoing, 1 incoming) treat the three low bits of req_addr as 0. The transfer covers req_len bytes from that aligned address.
- R11: With cfg_ecc=1, kind 1 with req_eom=0 extends its end up to the next multiple of 8 bytes, so its last access is a full 64-bit word.
- R12: acc_last is 1 on the final access of each request and 0 on every other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus64 | input | 1 | 1: 64-bit bus, 0: 32-bit bus |
| cfg_target64 | input | 1 | 1: target always accepts 64-bit accesses |
| cfg_ecc | input | 1 | ECC-memory alignment mode |
| cfg_big_endian | input | 1 | 1: big-endian storage order |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start address or descriptor base |
| req_len | input | LEN_W | Byte count for data kinds (at least 1) |
| req_eom | input | 1 | Transfer holds the end of message |
| req_kind | input | 2 | 0 outgoing data, 1 incoming data, 2 status write, 3 full descriptor write |
| acc_valid | output | 1 | Access present |
| acc_ready | input | 1 | Access taken by the bus master |
| acc_addr | output | ADDR_W | Aligned access address |
| acc_wide | output | 1 | 1: 64-bit access, 0: 32-bit access |
| acc_be_n | output | 8 | Active-low byte enables per lane |
| acc_last | output | 1 | Final access of the request |

## Verification
The assertions assume that the configuration inputs stay constant from the moment a request is taken until its last access is acknowledged. They also assume that no transfer crosses the top of the address space. The bench changes the configuration only between requests, with the block idle. It draws data addresses from the lower megabyte and keeps byte counts between 1 and 40, so the end address cannot wrap. Descriptor requests always use a base with its three low bits at zero, as R8 requires.

// File: rtl/dma_sizer_pkg.sv
package dma_sizer_pkg;
    localparam int LANES = 8;

    typedef enum logic [1:0] {
        KIND_TX   = 2'd0,
        KIND_RX   = 2'd1,
        KIND_STAT = 2'd2,
        KIND_FULL = 2'd3
    } req_kind_e;
endpackage

// File: rtl/dma_sizer_decode.sv
module dma_sizer_decode
    import dma_sizer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              eom_i,
    input  req_kind_e         kind_i,
    input  logic              bus64_i,
    input  logic              target64_i,
    input  logic              ecc_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W:0]   stop_o,
    output logic              narrow_o
);
    localparam logic [ADDR_W:0] EIGHT = (ADDR_W+1)'(8);
    localparam logic [ADDR_W:0] MASK8 = ~((ADDR_W+1)'(7));

    logic [ADDR_W:0] word_end;
    logic            same_word;

    always_comb begin
        start_o = addr_i;
        stop_o  = {1'b0, addr_i} + (ADDR_W+1)'(len_i);
        unique case (kind_i)
            KIND_STAT: begin
                // Status dword is the upper half of the descriptor
                start_o = ecc_i ? addr_i : addr_i + ADDR_W'(4);
                stop_o  = {1'b0, addr_i} + EIGHT;
            end
            KIND_FULL: begin
                start_o = addr_i;
                stop_o  = {1'b0, addr_i} + EIGHT;
            end
            default: begin
                if (ecc_i) begin
                    start_o = {addr_i[ADDR_W-1:3], 3'b000};
                end
                stop_o = {1'b0, start_o} + (ADDR_W+1)'(len_i);
                if (ecc_i && kind_i == KIND_RX && !eom_i) begin
                    stop_o = (stop_o + (ADDR_W+1)'(7)) & MASK8;
                end
            end
        endcase
        word_end  = {1'b0, start_o[ADDR_W-1:3], 3'b000} + EIGHT;
        same_word = (stop_o <= word_end);
        narrow_o  = !bus64_i || (!target64_i && same_word);
    end
endmodule

// File: rtl/dma_sizer_step.sv
module dma_sizer_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [ADDR_W:0]   stop_i,
    input  logic              narrow_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] next_o,
    output logic              last_o,
    output logic [3:0]        lo_o,
    output logic [3:0]        hi_o
);
    logic [ADDR_W:0] bound_d;
    logic [ADDR_W:0] next_d;

    always_comb begin
        addr_o  = narrow_i ? {cur_i[ADDR_W-1:2], 2'b00} : {cur_i[ADDR_W-1:3], 3'b000};
        bound_d = {1'b0, addr_o} + (narrow_i ? (ADDR_W+1)'(4) : (ADDR_W+1)'(8));
        next_d  = (stop_i < bound_d) ? stop_i : bound_d;
        next_o  = next_d[ADDR_W-1:0];
        last_o  = (next_d == stop_i);
        lo_o    = {1'b0, cur_i[2:0] & (narrow_i ? 3'b011 : 3'b111)};
        hi_o    = next_d[3:0] - addr_o[3:0];
    end
endmodule

// File: rtl/dma_sizer_lanes.sv
module dma_sizer_lanes
    import dma_sizer_pkg::*;
(
    input  logic             narrow_i,
    input  logic             big_i,
    input  logic [3:0]       lo_i,
    input  logic [3:0]       hi_i,
    output logic [LANES-1:0] be_n_o
);
    logic [3:0] wid_d;
    assign wid_d = narrow_i ? 4'd4 : 4'd8;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [3:0] off_d;
        logic       en_d;
        assign off_d     = big_i ? (wid_d - 4'd1 - 4'(j)) : 4'(j);
        assign en_d      = (4'(j) < wid_d) && (off_d >= lo_i) && (off_d < hi_i);
        assign be_n_o[j] = ~en_d;
    end
endmodule

// File: rtl/dma_sizer.sv
module dma_sizer
    import dma_sizer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus64,
    input  logic              cfg_target64,
    input  logic              cfg_ecc,
    input  logic              cfg_big_endian,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_eom,
    input  logic [1:0]        req_kind,
    output logic              acc_valid,
    input  logic              acc_ready,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_wide,
    output logic [7:0]        acc_be_n,
    output logic              acc_last
);
    typedef struct packed {
        logic              busy;
        logic              narrow;
        logic              big;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W:0]   stop;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] dec_start;
    logic [ADDR_W:0]   dec_stop;
    logic              dec_narrow;
    logic [ADDR_W-1:0] stp_next;
    logic              stp_last;
    logic [3:0]        stp_lo, stp_hi;

    dma_sizer_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_decode (
        .addr_i     (req_addr),
        .len_i      (req_len),
        .eom_i      (req_eom),
        .kind_i     (req_kind_e'(req_kind)),
        .bus64_i    (cfg_bus64),
        .target64_i (cfg_target64),
        .ecc_i      (cfg_ecc),
        .start_o    (dec_start),
        .stop_o     (dec_stop),
        .narrow_o   (dec_narrow)
    );

    dma_sizer_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_i    (st_q.cur),
        .stop_i   (st_q.stop),
        .narrow_i (st_q.narrow),
        .addr_o   (acc_addr),
        .next_o   (stp_next),
        .last_o   (stp_last),
        .lo_o     (stp_lo),
        .hi_o     (stp_hi)
    );

    dma_sizer_lanes u_lanes (
        .narrow_i (st_q.narrow),
        .big_i    (st_q.big),
        .lo_i     (stp_lo),
        .hi_i     (stp_hi),
        .be_n_o   (acc_be_n)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy   = 1'b1;
                st_d.cur    = dec_start;
                st_d.stop   = dec_stop;
                st_d.narrow = dec_narrow;
                st_d.big    = cfg_big_endian;
            end
        end else if (acc_ready) begin
            st_d.cur = stp_next;
            if (stp_last) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign acc_valid = st_q.busy;
    assign acc_wide  = !st_q.narrow;
    assign acc_last  = stp_last;
endmodule

// File: rtl/dma_sizer_chk.sv
module dma_sizer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_bus64,
    input logic              req_valid,
    input logic              req_ready,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wide,
    input logic [7:0]        acc_be_n,
    input logic              acc_last
);
    // R2
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> acc_valid && !req_ready);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_be_n) && $stable(acc_wide));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && acc_last |=> req_ready && !acc_valid);

    // R3
    bus32_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !cfg_bus64 |-> !acc_wide);

    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_addr[1:0] == 2'b00 && (!acc_wide || !acc_addr[2]));

    // R6
    upper_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_wide |-> acc_be_n[7:4] == 4'hF);

    // R6
    some_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_be_n != 8'hFF);
endmodule

bind dma_sizer dma_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_bus64 (cfg_bus64),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_addr  (acc_addr),
    .acc_wide  (acc_wide),
    .acc_be_n  (acc_be_n),
    .acc_last  (acc_last)
);

// File: tb/dma_sizer_tb.sv
module dma_sizer_tb;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cfg_bus64 = 1'b0, cfg_target64 = 1'b0, cfg_ecc = 1'b0, cfg_big_endian = 1'b0;
    logic          req_valid = 1'b0, req_eom = 1'b0, acc_ready = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [1:0]    req_kind = '0;
    logic          req_ready, acc_valid, acc_wide, acc_last;
    logic [AW-1:0] acc_addr;
    logic [7:0]    acc_be_n;

    dma_sizer #(.ADDR_W(AW), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_bus64(cfg_bus64), .cfg_target64(cfg_target64),
        .cfg_ecc(cfg_ecc), .cfg_big_endian(cfg_big_endian),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_eom(req_eom), .req_kind(req_kind),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
        .acc_wide(acc_wide), .acc_be_n(acc_be_n), .acc_last(acc_last)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [AW-1:0] e_addr [64];
    logic          e_wide [64];
    logic [7:0]    e_be   [64];
    int            e_n;
    logic [7:0]    first_be;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected access list built byte by byte from the requirements
    task automatic build_expect(input logic [AW-1:0] a, input int len, input logic eom, input logic [1:0] kind);
        longint s, e, base;
        int     unit;
        logic   nar;
        logic [7:0] be;
        case (kind)
            2'd2: begin s = cfg_ecc ? longint'(a) : longint'(a) + 4; e = longint'(a) + 8; end
            2'd3: begin s = longint'(a); e = longint'(a) + 8; end
            default: begin
                s = cfg_ecc ? (longint'(a) & ~longint'(7)) : longint'(a);
                e = s + len;
                if (cfg_ecc && kind == 2'd1 && !eom) e = ((e + 7) / 8) * 8;
            end
        endcase
        nar  = !cfg_bus64 || (!cfg_target64 && (s / 8 == (e - 1) / 8));
        unit = nar ? 4 : 8;
        e_n  = 0;
        for (longint w = s / unit; w <= (e - 1) / unit; w++) begin
            base = w * unit;
            be   = 8'hFF;
            for (int b = 0; b < unit; b++) begin
                if (base + b >= s && base + b < e) be[cfg_big_endian ? unit - 1 - b : b] = 1'b0;
            end
            e_addr[e_n] = AW'(base);
            e_wide[e_n] = !nar;
            e_be[e_n]   = be;
            e_n++;
        end
    endtask

    function automatic string classify(input logic [1:0] kind, input logic eom);
        if (kind >= 2'd2) return (cfg_ecc && kind == 2'd2) ? "R9" : "R8";
        if (cfg_ecc) return (kind == 2'd1 && !eom) ? "R11" : "R10";
        if (!cfg_bus64) return "R3";
        return cfg_big_endian ? "R7" : "R5/R4";
    endfunction

    task automatic run_req(input logic [AW-1:0] a, input int len, input logic eom, input logic [1:0] kind);
        string tag;
        int idx, guard;
        tag = classify(kind, eom);
        build_expect(a, len, eom, kind);
        @(negedge clk);
        chk("R2 idle before request", {63'd0, req_ready}, 64'd1);
        req_addr = a; req_len = LW'(len); req_eom = eom; req_kind = kind; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 valid after accept", {62'd0, acc_valid, req_ready}, 64'd2);
        idx = 0;
        guard = 0;
        while (idx < e_n && guard < 500) begin
            acc_ready = ($urandom % 4) != 0;
            #1;
            if (acc_valid && acc_ready) begin
                if (idx == 0) first_be = acc_be_n;
                chk($sformatf("%s R6 R12 access %0d", tag, idx),
                    {22'd0, acc_addr, acc_wide, acc_be_n, acc_last},
                    {22'd0, e_addr[idx], e_wide[idx], e_be[idx], idx == e_n - 1});
                idx++;
            end
            @(negedge clk);
            guard++;
        end
        acc_ready = 1'b0;
        chk("R2 access count", 64'(idx), 64'(e_n));
        chk("R2 idle after last", {62'd0, req_ready, acc_valid}, 64'd2);
    endtask

    task automatic set_cfg(input logic b64, input logic t64, input logic ecc, input logic big);
        cfg_bus64 = b64; cfg_target64 = t64; cfg_ecc = ecc; cfg_big_endian = big;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [1:0] k;
        logic [AW-1:0] a;
        void'($urandom(32'd7));
        #12;
        chk("R1 reset state", {62'd0, req_ready, acc_valid}, 64'd2);
        @(negedge clk);
        rst_n = 1'b1;

        set_cfg(1'b0, 1'b0, 1'b0, 1'b0); run_req(32'h1006, 7, 1'b1, 2'd0);      // R3
        chk("R3 first dword lanes", 64'(first_be), 64'hF3);
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0); run_req(32'h200, 8, 1'b1, 2'd0);       // R4 two dwords
        run_req(32'h204, 4, 1'b1, 2'd1);                                         // R4 one dword
        run_req(32'h203, 10, 1'b1, 2'd0);                                        // R5 spans words
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0); run_req(32'h200, 3, 1'b1, 2'd0);       // R5 target wide
        set_cfg(1'b1, 1'b1, 1'b0, 1'b1); run_req(32'h101, 2, 1'b1, 2'd0);       // R7
        chk("R7 reversed lanes", 64'(first_be), 64'h9F);
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0); run_req(32'h400, 1, 1'b0, 2'd2);       // R8 status
        chk("R8 status upper half", 64'(first_be), 64'h0F);
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0); run_req(32'h400, 0, 1'b0, 2'd3);       // R8 full
        set_cfg(1'b1, 1'b1, 1'b1, 1'b0); run_req(32'h400, 0, 1'b0, 2'd2);       // R9
        chk("R9 whole descriptor", 64'(first_be), 64'h00);
        run_req(32'h305, 5, 1'b1, 2'd0);                                         // R10
        chk("R10 masked pointer", 64'(first_be), 64'hE0);
        run_req(32'h300, 5, 1'b0, 2'd1);                                         // R11
        chk("R11 padded word", 64'(first_be), 64'h00);
        run_req(32'h300, 5, 1'b1, 2'd1);                                         // R11 eom: no pad
        chk("R11 eom not padded", 64'(first_be), 64'hE0);

        for (int i = 0; i < 400; i++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
            k = 2'($urandom % 4);
            a = $urandom & 32'h000F_FFFF;
            if (k >= 2'd2) a[2:0] = 3'b000;
            run_req(a, 1 + ($urandom % 40), 1'($urandom % 2), k);
        end
        finish_run();
    end
endmodule